// File: doc/BRIEF.md
# Glitch-Free Multi-Output Clock Gating Controller

This block takes a single reference clock and produces nine gated copies of it. A copy runs only while two conditions hold: its board-level enable pin is high, and its enable bit from the register file is high. Six enable pins serve the nine copies. Copies 0 to 3 each have a pin of their own. Pin 4 serves copies 4 and 5 together, and pin 5 serves copies 6, 7 and 8 together. Each request passes through a two-flop synchronizer on the reference clock. A latch that is open only while the clock is low holds the gate. Because of this, a copy can start or stop only at a clock-low boundary, and it never produces a shortened pulse.

One input is a combined power-good / power-down pin. After reset the block waits for this pin to be sampled high. While it waits, every copy is held off, but the serial configuration logic stays awake. After the first high sample the same pin becomes an active-low power-down. A low level on it stops every copy and also signals the serial logic to shut down. A later high level restarts the copies. Only reset brings the block back to the waiting state.

Top module: `clkgate_ctrl`

## Requirements
- R1: Copy i runs only while both its board enable pin and `reg_oe[i]` are high. Either one low stops it.
- R2: Pin mapping: `hw_oe[k]` drives copy k for k = 0 to 3, `hw_oe[4]` drives copies 4 and 5, and `hw_oe[5]` drives copies 6, 7 and 8.
- R3: Every `clk_out` bit is low whenever `clk_ref` is low. An enabled copy follows `clk_ref` for the whole of each high phase.
- R4: If a request (pin or register bit) changes while `clk_ref` is low, the copy's first change shows at the third rising edge after the change. A stopping copy still gives its pulse at the second edge and stays low from the third. A starting copy gives its first pulse at the third edge.
- R5: After reset, while `pwr_ok_n_pd` has not yet been sampled high, all copies are off and `serial_alive` is 1.
- R6: The first high sample of `pwr_ok_n_pd` enables the copies. Its first pulse appears at the fourth rising edge after the pin rises.
- R7: After activation, a low on `pwr_ok_n_pd` enters power-down. `serial_alive` goes to 0 after the third rising edge. Copies stay low from the fourth edge, and changes to enables have no effect while the block is powered down.
- R8: A high on `pwr_ok_n_pd` during power-down restarts the enabled copies with the same latency as R6, and `serial_alive` returns to 1 after the third edge. Once the block has left the waiting state, it never returns to it except through reset.
- R9: Synchronous active-high `rst` returns the block to the waiting state: all copies off and `serial_alive` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock to be gated |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok_n_pd | input | 1 | Power-good at start-up, active-low power-down afterwards |
| hw_oe | input | 6 | Board enable pins (mapping in R2) |
| reg_oe | input | 9 | Per-copy enable bits from the register file |
| clk_out | output | 9 | Gated clock copies |
| serial_alive | output | 1 | 1 while the serial logic may run, 0 in power-down |

## Verification
The checker verifies on every cycle four properties:
- each held gate is backed by the request that was present two edges earlier;
- no gate is open outside the active state;
- the state never falls back to waiting;
- power-down is entered only from the active state, and activation only follows a high pin sample.

The bench scenarios are what show the parts that need timed stimulus:
- the exact start and stop edges;
- full-width pulses and quiet low phases;
- the shared-pin mapping;
- the fact that enable changes are ignored while powered down.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    localparam int unsigned OUT_COUNT   = 9;
    localparam int unsigned PIN_COUNT   = 6;
    localparam int unsigned SYNC_DEPTH  = 2;
    localparam int unsigned SOLO_PINS   = 4;   // copies 0..3 own a pin each
    localparam int unsigned PAIR_LAST   = 5;   // copies 4..5 share pin SOLO_PINS

    typedef enum logic [1:0] {
        PWR_WAIT   = 2'd0,
        PWR_ACTIVE = 2'd1,
        PWR_DOWN   = 2'd2
    } pwr_state_e;

    // Board enable pin that serves a given clock copy
    function automatic int unsigned pin_of_out(input int unsigned idx);
        if (idx < SOLO_PINS)
            return idx;
        else if (idx <= PAIR_LAST)
            return SOLO_PINS;
        else
            return SOLO_PINS + 1;
    endfunction

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++)
                chain[s] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < int'(STAGES); s++)
                chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cg_pwr_fsm.sv
module cg_pwr_fsm
    import clkgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_high,
    output pwr_state_e state,
    output logic       run,
    output logic       serial_alive
);

    pwr_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            PWR_WAIT:   if (pin_high)  state_nxt = PWR_ACTIVE;
            PWR_ACTIVE: if (!pin_high) state_nxt = PWR_DOWN;
            PWR_DOWN:   if (pin_high)  state_nxt = PWR_ACTIVE;
            default:                   state_nxt = PWR_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PWR_WAIT;
        else     state <= state_nxt;
    end

    assign run          = (state == PWR_ACTIVE);
    assign serial_alive = (state != PWR_DOWN);

endmodule

// File: rtl/cg_gate_cell.sv
module cg_gate_cell (
    input  logic clk,
    input  logic en,
    output logic held,
    output logic gclk
);

    // Transparent only in the low phase: the gate cannot move while clk is high
    always_latch begin
        if (!clk) held <= en;
    end

    assign gclk = clk & held;

endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int unsigned NUM_OUT = OUT_COUNT,
    parameter int unsigned NUM_PIN = PIN_COUNT,
    parameter int unsigned STAGES  = SYNC_DEPTH
) (
    input  logic               clk_ref,
    input  logic               rst,
    input  logic               pwr_ok_n_pd,
    input  logic [NUM_PIN-1:0] hw_oe,
    input  logic [NUM_OUT-1:0] reg_oe,
    output logic [NUM_OUT-1:0] clk_out,
    output logic               serial_alive
);

    logic [NUM_OUT-1:0] req_raw;
    logic [NUM_OUT-1:0] req_sync;
    logic [NUM_OUT-1:0] gate_held;
    logic               pin_sync;
    logic               run;
    pwr_state_e         pwr_state;

    for (genvar i = 0; i < int'(NUM_OUT); i++) begin : g_req
        localparam int unsigned PIN = pin_of_out(i);
        assign req_raw[i] = hw_oe[PIN] & reg_oe[i];
    end

    cg_sync #(.WIDTH(NUM_OUT), .STAGES(STAGES)) u_req_sync (
        .clk     (clk_ref),
        .rst     (rst),
        .d_async (req_raw),
        .q_sync  (req_sync)
    );

    cg_sync #(.WIDTH(1), .STAGES(STAGES)) u_pin_sync (
        .clk     (clk_ref),
        .rst     (rst),
        .d_async (pwr_ok_n_pd),
        .q_sync  (pin_sync)
    );

    cg_pwr_fsm u_fsm (
        .clk          (clk_ref),
        .rst          (rst),
        .pin_high     (pin_sync),
        .state        (pwr_state),
        .run          (run),
        .serial_alive (serial_alive)
    );

    for (genvar i = 0; i < int'(NUM_OUT); i++) begin : g_gate
        cg_gate_cell u_cell (
            .clk  (clk_ref),
            .en   (run & req_sync[i]),
            .held (gate_held[i]),
            .gclk (clk_out[i])
        );
    end

endmodule

// File: rtl/cg_checker.sv
module cg_checker
    import clkgate_pkg::*;
#(
    parameter int unsigned NUM_OUT = OUT_COUNT,
    parameter int unsigned NUM_PIN = PIN_COUNT
) (
    input logic               clk_ref,
    input logic               rst,
    input logic               pwr_ok_n_pd,
    input logic [NUM_PIN-1:0] hw_oe,
    input logic [NUM_OUT-1:0] reg_oe,
    input logic               serial_alive,
    input pwr_state_e         state,
    input logic [NUM_OUT-1:0] gate_held
);

    for (genvar i = 0; i < int'(NUM_OUT); i++) begin : g_chk
        localparam int unsigned PIN = pin_of_out(i);
        // R1 R2
        gate_request_chk: assert property (@(posedge clk_ref) disable iff (rst)
            gate_held[i] |-> $past(hw_oe[PIN] & reg_oe[i], 2));
    end

    // R5 R7
    gate_off_idle_chk: assert property (@(posedge clk_ref) disable iff (rst)
        (state != PWR_ACTIVE) |-> (gate_held == '0));

    // R8
    no_return_wait_chk: assert property (@(posedge clk_ref) disable iff (rst)
        (state != PWR_WAIT) |=> (state != PWR_WAIT));

    // R7
    serial_drop_chk: assert property (@(posedge clk_ref) disable iff (rst)
        $fell(serial_alive) |-> ($past(state) == PWR_ACTIVE));

    // R6
    wake_needs_pin_chk: assert property (@(posedge clk_ref) disable iff (rst)
        ($past(state) == PWR_WAIT && state == PWR_ACTIVE) |-> $past(pwr_ok_n_pd, 3));

endmodule

bind clkgate_ctrl cg_checker #(.NUM_OUT(NUM_OUT), .NUM_PIN(NUM_PIN)) u_cg_checker (
    .clk_ref      (clk_ref),
    .rst          (rst),
    .pwr_ok_n_pd  (pwr_ok_n_pd),
    .hw_oe        (hw_oe),
    .reg_oe       (reg_oe),
    .serial_alive (serial_alive),
    .state        (pwr_state),
    .gate_held    (gate_held)
);

// File: tb/clkgate_ctrl_bench.sv
`timescale 1ns/1ps
module clkgate_ctrl_bench;

    localparam int PERIOD = 10;
    localparam int NVEC   = 8;
    // {hw_oe[5:0], reg_oe[8:0], expected clk_out high-phase[8:0]}  (R1 R2)
    localparam logic [23:0] VEC [NVEC] = '{
        {6'h3F, 9'h1FF, 9'h1FF},
        {6'h3E, 9'h1FF, 9'h1FE},
        {6'h2F, 9'h1FF, 9'h1CF},
        {6'h1F, 9'h1FF, 9'h03F},
        {6'h3F, 9'h0AA, 9'h0AA},
        {6'h15, 9'h1F0, 9'h030},
        {6'h2A, 9'h1FF, 9'h1CA},
        {6'h00, 9'h1FF, 9'h000}
    };

    logic       clk_ref = 1'b0;
    logic       rst = 1'b1;
    logic       pin = 1'b0;
    logic [5:0] hw_oe = 6'h3F;
    logic [8:0] reg_oe = 9'h1FF;
    logic [8:0] clk_out;
    logic       serial_alive;

    int errs = 0;
    int total = 0;

    clkgate_ctrl u_clkgate_ctrl (
        .clk_ref      (clk_ref),
        .rst          (rst),
        .pwr_ok_n_pd  (pin),
        .hw_oe        (hw_oe),
        .reg_oe       (reg_oe),
        .clk_out      (clk_out),
        .serial_alive (serial_alive)
    );

    always #(PERIOD/2) clk_ref = ~clk_ref;

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges_mid_high(input int n);
        repeat (n) @(posedge clk_ref);
        #2;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        errs++;
        total++;
        $display("FAIL watchdog act=running exp=done");
        summary();
    end

    initial begin
        // R9: reset state
        edges_mid_high(4);
        chk("R9 out in reset", clk_out, 9'h000);
        chk("R9 serial in reset", {8'h0, serial_alive}, 9'h001);
        @(negedge clk_ref) rst = 1'b0;

        // R5: waiting for power-good
        edges_mid_high(8);
        chk("R5 out while waiting", clk_out, 9'h000);
        chk("R5 serial while waiting", {8'h0, serial_alive}, 9'h001);

        // R6: first high sample, first pulse at 4th edge
        @(negedge clk_ref) pin = 1'b1;
        edges_mid_high(3);
        chk("R6 no pulse at 3rd edge", clk_out, 9'h000);
        edges_mid_high(1);
        chk("R6 pulse at 4th edge", clk_out, 9'h1FF);

        // R1 R2 R3: vector table
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk_ref);
            hw_oe  = VEC[v][23:18];
            reg_oe = VEC[v][17:9];
            edges_mid_high(6);
            chk($sformatf("R1 R2 vec%0d early high", v), clk_out, VEC[v][8:0]);
            #2;
            chk($sformatf("R3 vec%0d late high", v), clk_out, VEC[v][8:0]);
            @(negedge clk_ref); #2;
            chk($sformatf("R3 vec%0d low phase", v), clk_out, 9'h000);
        end

        // R4: start/stop latency via pin and register bit
        @(negedge clk_ref); hw_oe = 6'h3F; reg_oe = 9'h1FF;
        edges_mid_high(6);
        @(negedge clk_ref) hw_oe[0] = 1'b0;
        edges_mid_high(2);
        chk("R4 stop keeps 2nd pulse", {8'h0, clk_out[0]}, 9'h001);
        edges_mid_high(1);
        chk("R4 stop at 3rd edge", {8'h0, clk_out[0]}, 9'h000);
        @(negedge clk_ref) hw_oe[0] = 1'b1;
        edges_mid_high(2);
        chk("R4 start not before 3rd", {8'h0, clk_out[0]}, 9'h000);
        edges_mid_high(1);
        chk("R4 start at 3rd edge", {8'h0, clk_out[0]}, 9'h001);
        @(negedge clk_ref) reg_oe[8] = 1'b0;
        edges_mid_high(3);
        chk("R4 reg bit stop", clk_out, 9'h0FF);
        @(negedge clk_ref) reg_oe[8] = 1'b1;
        edges_mid_high(6);

        // R7: power-down
        @(negedge clk_ref) pin = 1'b0;
        edges_mid_high(2);
        chk("R7 serial still up at 2nd", {8'h0, serial_alive}, 9'h001);
        edges_mid_high(1);
        chk("R7 serial down at 3rd", {8'h0, serial_alive}, 9'h000);
        chk("R7 last pulse at 3rd", clk_out, 9'h1FF);
        edges_mid_high(1);
        chk("R7 off at 4th", clk_out, 9'h000);
        @(negedge clk_ref); reg_oe = 9'h155; hw_oe = 6'h00;
        @(negedge clk_ref); hw_oe = 6'h3F;
        edges_mid_high(6);
        chk("R7 enables ignored", clk_out, 9'h000);
        chk("R7 serial stays down", {8'h0, serial_alive}, 9'h000);

        // R8: recovery
        @(negedge clk_ref) pin = 1'b1;
        edges_mid_high(2);
        chk("R8 serial down at 2nd", {8'h0, serial_alive}, 9'h000);
        edges_mid_high(1);
        chk("R8 serial up at 3rd", {8'h0, serial_alive}, 9'h001);
        chk("R8 no pulse at 3rd", clk_out, 9'h000);
        edges_mid_high(1);
        chk("R8 resume at 4th", clk_out, 9'h155);

        // R9: reset returns to waiting, not power-down
        @(negedge clk_ref); rst = 1'b1; pin = 1'b0;
        edges_mid_high(3);
        @(negedge clk_ref) rst = 1'b0;
        edges_mid_high(8);
        chk("R9 waiting out", clk_out, 9'h000);
        chk("R9 waiting serial", {8'h0, serial_alive}, 9'h001);
        @(negedge clk_ref) pin = 1'b1;
        edges_mid_high(6);
        chk("R6 restart after reset", clk_out, 9'h155);

        summary();
    end

endmodule